// File: doc/BRIEF.md
# Daisy-Chain Readback Frame Decoder

This block sits behind the serial receiver of a battery-monitor chain controller. Each 32-bit word that has been shifted in from the chain is handed over with a one-cycle `in_valid` strobe. The block verifies the word's 8-bit checksum and splits the word into its fields. A mode input chooses the layout. In conversion layout the word carries a 4-bit channel number and a 12-bit result. In register layout it carries a 6-bit register number and an 8-bit value. All results appear together, registered, one cycle later with `out_valid`.

A word of all zeros means no further device answered. It is flagged as end of chain and never counts as a checksum failure. When comparison is enabled, a well-formed frame whose device or address differs from the expected pair raises an identity-mismatch flag. This flag is separate from the checksum flag. A running sum collects the results of the cell-voltage channels (0 to 5) from good conversion frames. The auxiliary channels (6 to 11) do not add to it. A `sum_clear` strobe restarts the sum.

A two-state output sequencer drives `out_valid`. **ST_IDLE** is entered at reset and holds `out_valid` low. The transition *accept* (an `in_valid` cycle) moves it to **ST_EMIT**, where `out_valid` is high for that cycle. From ST_EMIT, *accept* keeps it in ST_EMIT for back-to-back words. The transition *drain* (no `in_valid`) returns it to ST_IDLE.

Top module: `rb_frame_decoder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. All decoded outputs change only on such an update and otherwise hold their value.
- R2: With `read_is_reg`=0 (conversion layout), `out_dev` = word[31:27], `out_addr` = word[26:23] zero-extended to 6 bits, and `out_data` = word[22:11].
- R3: With `read_is_reg`=1 (register layout), `out_dev` = word[31:27], `out_addr` = word[26:21], and `out_data` = word[20:13] with bits 11:8 of `out_data` forced to zero.
- R4: `out_ack` = word[10] in both layouts.
- R5: The checksum is formed over v = word[31:10]. Run an MSB-first CRC-8 with polynomial 0x2F and zero start value over v[21:8], then XOR the result with v[7:0]. `crc_err` is 1 when this value differs from word[9:2] and the word is not all zeros.
- R6: An all-zero word gives `chain_end`=1, `crc_err`=0 and `id_mismatch`=0, and it leaves `cell_sum` unchanged. Any other word gives `chain_end`=0.
- R7: `id_mismatch` is 1 when all of these hold: `cmp_en`=1, the checksum is good, the word is not all zeros, and either `out_dev` differs from `exp_dev` or `out_addr` differs from `exp_addr`. It is 0 in every other case.
- R8: `cell_sum` (32 bits, wrapping) adds `out_data` only for a frame that meets all of these: conversion layout, good checksum, not all zeros, and channel 0 to 5. Auxiliary channels, register frames and bad frames leave it unchanged.
- R9: On a `sum_clear` cycle the new sum is zero plus the contribution of the frame accepted in that same cycle, if that frame contributes.
- R10: After reset `out_valid`, all flags, all fields and `cell_sum` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received word is present |
| in_word | input | 32 | Received chain word |
| read_is_reg | input | 1 | 0 = conversion layout, 1 = register layout |
| cmp_en | input | 1 | Enable comparison against the expected identity |
| exp_dev | input | 5 | Expected device address |
| exp_addr | input | 6 | Expected channel or register address |
| sum_clear | input | 1 | Restart the cell-voltage sum |
| out_valid | output | 1 | Decoded results updated this cycle |
| out_dev | output | 5 | Device address field |
| out_addr | output | 6 | Channel or register address field |
| out_data | output | 12 | Data field |
| out_ack | output | 1 | Write-acknowledge bit |
| crc_err | output | 1 | Checksum failure |
| chain_end | output | 1 | All-zero word: no more devices |
| id_mismatch | output | 1 | Identity differs from expectation |
| cell_sum | output | 32 | Running sum of cell-voltage results |

## Verification
The block is tested with several kinds of word:
- Full sweeps of three devices over all twelve channels, which separate cell channels from auxiliary channels in the sum.
- Register frames, which show whether the 6/8-bit layout is decoded instead of the 4/12-bit one.
- Words with a single flipped bit, placed in the acknowledge bit, a data bit or the checksum field. These show that the checksum covers bit 10 and that a bad frame stays out of the sum and never reports a mismatch.
- All-zero words, which separate end of chain from checksum failure.
- Alternating right and wrong expected identities, idle gaps and clear strobes, both alone and together with a frame, which exercise the hold, compare and restart rules.

A long pseudo-random run mixes all of these cases.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
    localparam int WORD_W   = 32;
    localparam int DEV_W    = 5;
    localparam int CHAN_W   = 4;
    localparam int RADDR_W  = 6;
    localparam int CDATA_W  = 12;
    localparam int RDATA_W  = 8;
    localparam int CRC_W    = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;

    localparam int DEV_HI   = WORD_W - 1;
    localparam int DEV_LO   = DEV_HI - DEV_W + 1;
    localparam int CH_HI    = DEV_LO - 1;
    localparam int CH_LO    = CH_HI - CHAN_W + 1;
    localparam int CD_HI    = CH_LO - 1;
    localparam int CD_LO    = CD_HI - CDATA_W + 1;
    localparam int RA_HI    = DEV_LO - 1;
    localparam int RA_LO    = RA_HI - RADDR_W + 1;
    localparam int RD_HI    = RA_LO - 1;
    localparam int RD_LO    = RD_HI - RDATA_W + 1;
    localparam int ACK_BIT  = CD_LO - 1;
    localparam int CRC_HI   = ACK_BIT - 1;
    localparam int CRC_LO   = CRC_HI - CRC_W + 1;
    localparam int COV_W    = WORD_W - ACK_BIT;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [DEV_W-1:0]   dev;
        logic [RADDR_W-1:0] addr;
        logic [CDATA_W-1:0] data;
        logic               ack;
    } frame_fields_t;

    // One byte pushed through the MSB-first CRC register from zero.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] x);
        logic [CRC_W-1:0] r;
        r = x;
        for (int i = 0; i < CRC_W; i++) begin
            r = r[CRC_W-1] ? ({r[CRC_W-2:0], 1'b0} ^ CRC_POLY) : {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction
endpackage

// File: rtl/fdec_crc_chk.sv
module fdec_crc_chk
    import fdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              crc_bad
);
    localparam int TOP_BITS = COV_W - 2 * CRC_W;

    logic [COV_W-1:0] cov;
    logic [CRC_W-1:0] stage1, stage2, calc;
    logic [CRC_LO-1:0] unused_low;

    assign cov        = word[WORD_W-1:ACK_BIT];
    assign unused_low = word[CRC_LO-1:0];

    always_comb begin
        stage1  = crc_byte({{(CRC_W-TOP_BITS){1'b0}}, cov[COV_W-1:2*CRC_W]});
        stage2  = crc_byte(stage1 ^ cov[2*CRC_W-1:CRC_W]);
        calc    = stage2 ^ cov[CRC_W-1:0];
        crc_bad = (calc != word[CRC_HI:CRC_LO]);
    end
endmodule

// File: rtl/fdec_field_split.sv
module fdec_field_split
    import fdec_pkg::*;
#(
    parameter int CELL_CH = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic              reg_layout,
    output frame_fields_t     fields,
    output logic              is_cell
);
    logic [CHAN_W-1:0] chan;
    logic [ACK_BIT-1:0] unused_tail;

    assign chan        = word[CH_HI:CH_LO];
    assign unused_tail = word[ACK_BIT-1:0];

    always_comb begin
        fields.dev = word[DEV_HI:DEV_LO];
        fields.ack = word[ACK_BIT];
        if (reg_layout) begin
            fields.addr = word[RA_HI:RA_LO];
            fields.data = {{(CDATA_W-RDATA_W){1'b0}}, word[RD_HI:RD_LO]};
            is_cell     = 1'b0;
        end else begin
            fields.addr = {{(RADDR_W-CHAN_W){1'b0}}, chan};
            fields.data = word[CD_HI:CD_LO];
            is_cell     = (int'(chan) < CELL_CH);
        end
    end
endmodule

// File: rtl/fdec_sum_acc.sv
module fdec_sum_acc
    import fdec_pkg::*;
#(
    parameter int SUM_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               add_en,
    input  logic [CDATA_W-1:0] add_val,
    output logic [SUM_W-1:0]   sum
);
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] addend;

    assign base   = clear ? '0 : sum;
    assign addend = add_en ? {{(SUM_W-CDATA_W){1'b0}}, add_val} : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) sum <= '0;
        else        sum <= base + addend;
    end
endmodule

// File: rtl/rb_frame_decoder.sv
module rb_frame_decoder
    import fdec_pkg::*;
#(
    parameter int CELL_CH = 6,
    parameter int SUM_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               read_is_reg,
    input  logic               cmp_en,
    input  logic [DEV_W-1:0]   exp_dev,
    input  logic [RADDR_W-1:0] exp_addr,
    input  logic               sum_clear,
    output logic               out_valid,
    output logic [DEV_W-1:0]   out_dev,
    output logic [RADDR_W-1:0] out_addr,
    output logic [CDATA_W-1:0] out_data,
    output logic               out_ack,
    output logic               crc_err,
    output logic               chain_end,
    output logic               id_mismatch,
    output logic [SUM_W-1:0]   cell_sum
);
    seq_state_t    state_q, state_d;
    frame_fields_t fld;
    logic          crc_bad, is_cell, zero_word, id_diff, add_en;

    fdec_crc_chk u_crc (
        .word    (in_word),
        .crc_bad (crc_bad)
    );

    fdec_field_split #(.CELL_CH(CELL_CH)) u_split (
        .word       (in_word),
        .reg_layout (read_is_reg),
        .fields     (fld),
        .is_cell    (is_cell)
    );

    assign zero_word = (in_word == '0);
    assign id_diff   = (fld.dev != exp_dev) || (fld.addr != exp_addr);
    assign add_en    = in_valid && !zero_word && !crc_bad && is_cell;

    fdec_sum_acc #(.SUM_W(SUM_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sum_clear),
        .add_en  (add_en),
        .add_val (fld.data),
        .sum     (cell_sum)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept / drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign out_valid = (state_q == ST_EMIT);

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dev     <= '0;
            out_addr    <= '0;
            out_data    <= '0;
            out_ack     <= 1'b0;
            crc_err     <= 1'b0;
            chain_end   <= 1'b0;
            id_mismatch <= 1'b0;
        end else if (in_valid) begin
            out_dev     <= fld.dev;
            out_addr    <= fld.addr;
            out_data    <= fld.data;
            out_ack     <= fld.ack;
            crc_err     <= crc_bad && !zero_word;
            chain_end   <= zero_word;
            id_mismatch <= cmp_en && !zero_word && !crc_bad && id_diff;
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_addr) && $stable(out_dev)));
    p_reg_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && read_is_reg) |=> (out_data[CDATA_W-1:RDATA_W] == '0));
    p_end_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && chain_end) |-> (!crc_err && !id_mismatch));
    p_err_no_mis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && crc_err) |-> !id_mismatch);
    p_sum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !sum_clear) |=> $stable(cell_sum));
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_clear && !in_valid) |=> (cell_sum == '0));
endmodule

// File: tb/rb_frame_decoder_tb_top.sv
module rb_frame_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, read_is_reg, cmp_en, sum_clear;
    logic [31:0] in_word;
    logic [4:0]  exp_dev;
    logic [5:0]  exp_addr;
    logic        out_valid, out_ack, crc_err, chain_end, id_mismatch;
    logic [4:0]  out_dev;
    logic [5:0]  out_addr;
    logic [11:0] out_data;
    logic [31:0] cell_sum;

    always #4 clk = ~clk;

    rb_frame_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .read_is_reg(read_is_reg), .cmp_en(cmp_en), .exp_dev(exp_dev),
        .exp_addr(exp_addr), .sum_clear(sum_clear), .out_valid(out_valid),
        .out_dev(out_dev), .out_addr(out_addr), .out_data(out_data),
        .out_ack(out_ack), .crc_err(crc_err), .chain_end(chain_end),
        .id_mismatch(id_mismatch), .cell_sum(cell_sum)
    );

    int n_chk = 0;
    int n_bad = 0;

    bit        e_valid, e_ack, e_err, e_end, e_mis, e_regmode;
    bit [4:0]  e_dev;
    bit [5:0]  e_addr;
    bit [11:0] e_data;
    bit [31:0] e_sum;
    bit        last_clr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Serial CRC over bits 31:18, then XOR with bits 17:10.
    function automatic bit [7:0] ref_crc(input bit [31:0] w);
        bit [7:0] c = 8'h00;
        bit fb;
        for (int i = 31; i >= 18; i--) begin
            fb = c[7] ^ w[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h2F;
        end
        return c ^ w[17:10];
    endfunction

    function automatic bit [31:0] mk_conv(input bit [4:0] d, input bit [3:0] ch,
                                          input bit [11:0] v, input bit a);
        bit [31:0] w = '0;
        w[31:27] = d; w[26:23] = ch; w[22:11] = v; w[10] = a;
        w[9:2] = ref_crc(w);
        return w;
    endfunction

    function automatic bit [31:0] mk_reg(input bit [4:0] d, input bit [5:0] ra,
                                         input bit [7:0] v, input bit a);
        bit [31:0] w = '0;
        w[31:27] = d; w[26:21] = ra; w[20:13] = v; w[10] = a;
        w[9:2] = ref_crc(w);
        return w;
    endfunction

    task automatic compare_all();
        chk("R1 out_valid", out_valid, e_valid);
        chk(e_regmode ? "R3 out_dev" : "R2 out_dev", out_dev, e_dev);
        chk(e_regmode ? "R3 out_addr" : "R2 out_addr", out_addr, e_addr);
        chk(e_regmode ? "R3 out_data" : "R2 out_data", out_data, e_data);
        chk("R4 out_ack", out_ack, e_ack);
        chk("R5 crc_err", crc_err, e_err);
        chk("R6 chain_end", chain_end, e_end);
        chk("R7 id_mismatch", id_mismatch, e_mis);
        chk(last_clr ? "R9 cell_sum" : "R8 cell_sum", cell_sum, e_sum);
    endtask

    // Called at a negedge: drive, model, wait one edge, compare.
    task automatic step(input bit vld, input bit [31:0] w, input bit md, input bit ce,
                        input bit [4:0] xd, input bit [5:0] xa, input bit clr);
        bit zero, bad;
        in_valid = vld; in_word = w; read_is_reg = md; cmp_en = ce;
        exp_dev = xd; exp_addr = xa; sum_clear = clr;
        last_clr = clr;
        if (clr) e_sum = 0;
        e_valid = vld;
        if (vld) begin
            zero = (w == 0);
            bad  = !zero && (ref_crc(w) != w[9:2]);
            e_regmode = md;
            e_dev = w[31:27];
            if (md) begin
                e_addr = w[26:21];
                e_data = {4'h0, w[20:13]};
            end else begin
                e_addr = {2'b00, w[26:23]};
                e_data = w[22:11];
            end
            e_ack = w[10];
            e_err = bad;
            e_end = zero;
            e_mis = ce && !zero && !bad && ((e_dev != xd) || (e_addr != xa));
            if (!md && !zero && !bad && (w[26:23] < 6)) e_sum = e_sum + e_data;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
        in_valid = 1'b0; sum_clear = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit [31:0] w;
        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; read_is_reg = 1'b0;
        cmp_en = 1'b0; exp_dev = '0; exp_addr = '0; sum_clear = 1'b0;
        e_valid = 0; e_dev = 0; e_addr = 0; e_data = 0; e_ack = 0; e_err = 0;
        e_end = 0; e_mis = 0; e_sum = 0; e_regmode = 0; last_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 out_valid", out_valid, 0);
        chk("R10 fields", {out_dev, out_addr, out_data, out_ack}, 0);
        chk("R10 flags", {crc_err, chain_end, id_mismatch}, 0);
        chk("R10 cell_sum", cell_sum, 0);
        rst_n = 1'b1;

        // Sweep: three devices, all channels, alternating right/wrong expectation.
        for (int d = 0; d < 3; d++) begin
            for (int ch = 0; ch < 12; ch++) begin
                w = mk_conv(5'(d), 4'(ch), 12'(d * 300 + ch * 17 + 5), ch[0]);
                step(1, w, 0, 1, 5'(d), (ch % 2 == 0) ? 6'(ch) : 6'(ch ^ 3), 0);
                if (ch % 5 == 4) step(0, 0, 0, 0, 0, 0, 0);
            end
        end
        // End of chain, with comparison armed against a nonzero identity.
        step(1, 32'h0, 0, 1, 5'd3, 6'd1, 0);
        step(1, 32'h0, 1, 1, 5'd3, 6'd1, 0);
        // Register frames: matching and mismatching.
        step(1, mk_reg(5'd2, 6'h0D, 8'hA5, 1), 1, 1, 5'd2, 6'h0D, 0);
        step(1, mk_reg(5'd2, 6'h1C, 8'hFF, 0), 1, 1, 5'd4, 6'h1C, 0);
        step(1, mk_reg(5'd1, 6'h3F, 8'h01, 1), 1, 1, 5'd1, 6'h3E, 0);
        // Corrupted cell frames: ack bit, data bit, checksum bit.
        step(1, mk_conv(5'd1, 4'd2, 12'h7FF, 0) ^ 32'h0000_0400, 0, 1, 5'd9, 6'd9, 0);
        step(1, mk_conv(5'd0, 4'd0, 12'hABC, 1) ^ 32'h0000_0800, 0, 1, 5'd9, 6'd9, 0);
        step(1, mk_conv(5'd0, 4'd5, 12'h123, 1) ^ 32'h0000_0004, 0, 0, 5'd0, 6'd0, 0);
        // Clear alone, then clear together with a cell frame.
        step(0, 0, 0, 0, 0, 0, 1);
        step(1, mk_conv(5'd3, 4'd4, 12'hFFF, 0), 0, 0, 0, 0, 0);
        step(1, mk_conv(5'd3, 4'd1, 12'h444, 1), 0, 0, 0, 0, 1);
        step(1, mk_conv(5'd3, 4'd9, 12'h555, 1), 0, 0, 0, 0, 1);
        // Pseudo-random mix.
        for (int k = 0; k < 400; k++) begin
            bit md, ce;
            bit [31:0] r;
            md = ($urandom % 4) == 0;
            ce = $urandom % 2;
            r  = $urandom;
            w  = md ? mk_reg(r[4:0], r[10:5], r[18:11], r[19])
                    : mk_conv(r[4:0], 4'(r[8:5] % 12), r[20:9], r[21]);
            if (($urandom % 4) == 0) w = w ^ (32'h1 << (2 + ($urandom % 30)));
            if (($urandom % 20) == 0) w = 32'h0;
            step(($urandom % 6) != 0, w, md, ce,
                 ($urandom % 2) ? w[31:27] : 5'($urandom),
                 ($urandom % 2) ? (md ? w[26:21] : {2'b00, w[26:23]}) : 6'($urandom),
                 ($urandom % 25) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule